// File: doc/BRIEF.md
# USB Device Bus Event Interrupt Controller

This block sits next to the serial interface engine of a USB device and turns bus-level conditions into sticky status flags. The conditions are supply changes, long idle stretches, bus reset, packet activity, the end of remote wakeup signalling and activity on the D+ line. Each flag has an enable bit of its own, and a single registered interrupt line tells the CPU that at least one enabled flag is set. Firmware clears flags and programs enables through a small write port. Both registers are always visible as output vectors.

Duration-based events are timed in bit times. A `bit_tick` strobe marks each bit time, which is one cycle of a 12 Mb/s line. One run-length counter measures how long the decoded line state has stayed the same, and it restarts whenever that state changes. From that count the block derives three events: suspend (long J idle), loss of bus activity (short J idle) and the end of remote wakeup (long K while a wakeup is being driven). A bus reset clears every flag except its own. The bus-reset flag clears itself when the reset ends.

Top module: `usb_bus_evt_irq`

## Requirements
- R1: A 0-to-1 change of `vbus_det` sets status bit 0 (supply present). A 1-to-0 change sets status bit 1 (supply lost).
- R2: Status bit 2 (suspend) sets once the line has been in J state (`line_state` = 2'b01) for IDLE_TICKS consecutive bit ticks. Any change of `line_state` restarts the count. The other encodings are 2'b00 SE0, 2'b10 K and 2'b11 SE1.
- R3: Status bit 3 (bus reset) sets on a rising edge of `bus_rst_det` and clears in the cycle after `bus_rst_det` falls. Software may also clear it while the reset is still active, and it stays clear until the next rising edge.
- R4: Status bit 4 (bus active) sets on `sync_rx`. It clears after J_TICKS consecutive bit ticks of J state, while `bus_rst_det` is high, or on a software clear.
- R5: Status bit 5 (wakeup done) sets when the line has been in K state for K_TICKS bit ticks while `rwu_req` is high. A K state of the same length without `rwu_req` sets nothing.
- R6: Status bit 6 (D+ activity) sets on `dp_pulse`.
- R7: While `bus_rst_det` is high, every status flag other than bit 3 is cleared.
- R8: A write with `reg_sel`=0 clears each status bit written as 0 and leaves each bit written as 1 unchanged. A write with `reg_sel`=1 loads the enable register. Bit 7 of both registers always reads 0. Bus reset leaves the enables unchanged.
- R9: `irq_o` is high in the cycle after some status bit and its enable bit are both 1, and it is low otherwise.
- R10: When a hardware set and a clear (software or hardware) hit the same flag in the same cycle, the flag ends up set.
- R11: After `rst`, both registers and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high controller reset |
| bit_tick | input | 1 | One-cycle strobe per bus bit time |
| vbus_det | input | 1 | Supply detect level |
| line_state | input | 2 | Decoded line state: 00 SE0, 01 J, 10 K, 11 SE1 |
| sync_rx | input | 1 | Strobe: SYNC field received |
| bus_rst_det | input | 1 | Level: bus reset condition present |
| rwu_req | input | 1 | Level: device is driving remote wakeup |
| dp_pulse | input | 1 | Strobe: activity seen on D+ |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 status, 1 enable |
| reg_wdata | input | 8 | Write data |
| status_o | output | 8 | Status flags |
| irq_en_o | output | 8 | Interrupt enables |
| irq_o | output | 1 | Level interrupt to the CPU, active high |

## Verification
The hardest situations to reach are those where two things hit the same flag in one cycle: a `sync_rx` strobe together with a clearing status write, and a software clear of the bus-reset flag while `bus_rst_det` is still high. The bench drives both inputs at the same falling edge, so they land on one rising edge. The timed events are approached by holding a line state for exactly one tick less than the limit, checking that the flag is still clear, and then giving one more tick. Restart of the count is shown by a one-cycle K glitch inside a J run.

// File: rtl/usb_evt_pkg.sv
package usb_evt_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_e;

    localparam int NFLAG   = 8;
    localparam int FL_VON  = 0;
    localparam int FL_VOFF = 1;
    localparam int FL_SUSP = 2;
    localparam int FL_BRST = 3;
    localparam int FL_BACT = 4;
    localparam int FL_WAKE = 5;
    localparam int FL_DPA  = 6;

    localparam logic [NFLAG-1:0] LIVE_MASK = 8'h7F;

    typedef struct packed {
        logic idle_hit;
        logic jrun_hit;
        logic wake_hit;
    } timer_ev_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/usb_evt_linetimer.sv
module usb_evt_linetimer
    import usb_evt_pkg::*;
#(
    parameter int IDLE_TICKS = 36000,
    parameter int J_TICKS    = 32,
    parameter int K_TICKS    = 120000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_tick,
    input  logic [1:0] line_state,
    input  logic       rwu_req,
    output timer_ev_t  ev
);
    localparam int MAXT = max2(max2(IDLE_TICKS, J_TICKS), K_TICKS);
    localparam int W    = $clog2(MAXT + 1);
    localparam logic [W-1:0] RUN_MAX = W'(MAXT);
    localparam logic [W-1:0] IDLE_M1 = W'(IDLE_TICKS - 1);
    localparam logic [W-1:0] J_M1    = W'(J_TICKS - 1);
    localparam logic [W-1:0] K_M1    = W'(K_TICKS - 1);

    line_e        line_q;
    line_e        line_now;
    logic [W-1:0] run_q;
    logic         chg;
    logic         adv;

    assign line_now = line_e'(line_state);
    assign chg      = (line_now != line_q);
    assign adv      = bit_tick && !chg;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= LS_SE0;
            run_q  <= '0;
        end else begin
            line_q <= line_now;
            if (chg)
                run_q <= '0;
            else if (bit_tick && run_q != RUN_MAX)
                run_q <= run_q + 1'b1;
        end
    end

    always_comb begin
        ev.idle_hit = adv && (line_q == LS_J) && (run_q == IDLE_M1);
        ev.jrun_hit = adv && (line_q == LS_J) && (run_q == J_M1);
        ev.wake_hit = adv && (line_q == LS_K) && rwu_req && (run_q == K_M1);
    end

endmodule

// File: rtl/usb_evt_flagbank.sv
module usb_evt_flagbank #(
    parameter int             N    = 8,
    parameter logic [N-1:0]   MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_v,
    input  logic [N-1:0] clr_v,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        if (MASK[i]) begin : g_live
            logic f_q;
            always_ff @(posedge clk) begin
                if (rst)
                    f_q <= 1'b0;
                else if (set_v[i])
                    f_q <= 1'b1;
                else if (clr_v[i])
                    f_q <= 1'b0;
            end
            assign q[i] = f_q;
        end else begin : g_resv
            assign q[i] = 1'b0;
        end
    end

endmodule

// File: rtl/usb_evt_enreg.sv
module usb_evt_enreg #(
    parameter int           N    = 8,
    parameter logic [N-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] q
);
    logic [N-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (we)
            en_q <= wdata & MASK;
    end

    assign q = en_q;

endmodule

// File: rtl/usb_bus_evt_irq.sv
module usb_bus_evt_irq
    import usb_evt_pkg::*;
#(
    parameter int IDLE_TICKS = 36000,
    parameter int J_TICKS    = 32,
    parameter int K_TICKS    = 120000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_tick,
    input  logic       vbus_det,
    input  logic [1:0] line_state,
    input  logic       sync_rx,
    input  logic       bus_rst_det,
    input  logic       rwu_req,
    input  logic       dp_pulse,
    input  logic       reg_we,
    input  logic       reg_sel,
    input  logic [7:0] reg_wdata,
    output logic [7:0] status_o,
    output logic [7:0] irq_en_o,
    output logic       irq_o
);
    timer_ev_t        tev;
    logic             vbus_q;
    logic             brst_q;
    logic [NFLAG-1:0] set_v;
    logic [NFLAG-1:0] hw_clr;
    logic [NFLAG-1:0] sw_clr;
    logic [NFLAG-1:0] flags;
    logic [NFLAG-1:0] en;
    logic             irq_q;

    usb_evt_linetimer #(
        .IDLE_TICKS (IDLE_TICKS),
        .J_TICKS    (J_TICKS),
        .K_TICKS    (K_TICKS)
    ) i_timer (
        .clk        (clk),
        .rst        (rst),
        .bit_tick   (bit_tick),
        .line_state (line_state),
        .rwu_req    (rwu_req),
        .ev         (tev)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vbus_q <= 1'b0;
            brst_q <= 1'b0;
        end else begin
            vbus_q <= vbus_det;
            brst_q <= bus_rst_det;
        end
    end

    always_comb begin
        set_v          = '0;
        set_v[FL_VON]  = vbus_det & ~vbus_q;
        set_v[FL_VOFF] = ~vbus_det & vbus_q;
        set_v[FL_SUSP] = tev.idle_hit;
        set_v[FL_BRST] = bus_rst_det & ~brst_q;
        set_v[FL_BACT] = sync_rx;
        set_v[FL_WAKE] = tev.wake_hit;
        set_v[FL_DPA]  = dp_pulse;

        hw_clr          = {NFLAG{bus_rst_det}};
        hw_clr[FL_BRST] = ~bus_rst_det & brst_q;
        hw_clr[FL_BACT] = bus_rst_det | tev.jrun_hit;

        sw_clr = (reg_we && !reg_sel) ? ~reg_wdata : '0;
    end

    usb_evt_flagbank #(
        .N    (NFLAG),
        .MASK (LIVE_MASK)
    ) i_flags (
        .clk   (clk),
        .rst   (rst),
        .set_v (set_v),
        .clr_v (hw_clr | sw_clr),
        .q     (flags)
    );

    usb_evt_enreg #(
        .N    (NFLAG),
        .MASK (LIVE_MASK)
    ) i_en (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we && reg_sel),
        .wdata (reg_wdata),
        .q     (en)
    );

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= |(flags & en);
    end

    assign status_o = flags;
    assign irq_en_o = en;
    assign irq_o    = irq_q;

endmodule

// File: rtl/usb_bus_evt_irq_chk.sv
module usb_bus_evt_irq_chk (
    input logic       clk,
    input logic       rst,
    input logic       vbus_det,
    input logic       sync_rx,
    input logic       bus_rst_det,
    input logic       reg_we,
    input logic       reg_sel,
    input logic [7:0] reg_wdata,
    input logic [7:0] status_o,
    input logic [7:0] irq_en_o,
    input logic       irq_o
);
    p_vbus_rise_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(vbus_det) |=> status_o[0]);

    p_brst_gone_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_rst_det) |-> !status_o[3]);

    p_bact_held_low_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_rst_det) && !$past(sync_rx)) |-> !status_o[4]);

    p_swclr_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_we && !reg_sel && !reg_wdata[0] && !$rose(vbus_det)) |=> !status_o[0]);

    p_irq_level_r9: assert property (@(posedge clk) disable iff (rst)
        irq_o == $past(|(status_o & irq_en_o)));

    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (sync_rx && reg_we && !reg_sel && !reg_wdata[4]) |=> status_o[4]);

    p_resv_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !status_o[7] && !irq_en_o[7]);

endmodule

bind usb_bus_evt_irq usb_bus_evt_irq_chk i_chk (.*);

// File: tb/test_usb_bus_evt_irq.sv
module test_usb_bus_evt_irq;

    localparam int IDLE_T = 40;
    localparam int J_T    = 8;
    localparam int K_T    = 24;

    logic       clk = 1'b0;
    logic       rst;
    logic       bit_tick;
    logic       vbus_det;
    logic [1:0] line_state;
    logic       sync_rx;
    logic       bus_rst_det;
    logic       rwu_req;
    logic       dp_pulse;
    logic       reg_we;
    logic       reg_sel;
    logic [7:0] reg_wdata;
    logic [7:0] status_o;
    logic [7:0] irq_en_o;
    logic       irq_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    usb_bus_evt_irq #(
        .IDLE_TICKS (IDLE_T),
        .J_TICKS    (J_T),
        .K_TICKS    (K_T)
    ) i_usb_bus_evt_irq (
        .clk         (clk),
        .rst         (rst),
        .bit_tick    (bit_tick),
        .vbus_det    (vbus_det),
        .line_state  (line_state),
        .sync_rx     (sync_rx),
        .bus_rst_det (bus_rst_det),
        .rwu_req     (rwu_req),
        .dp_pulse    (dp_pulse),
        .reg_we      (reg_we),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .status_o    (status_o),
        .irq_en_o    (irq_en_o),
        .irq_o       (irq_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        step(1);
        reg_we = 1'b0;
    endtask

    task automatic pulse_sync();
        sync_rx = 1'b1; step(1); sync_rx = 1'b0;
    endtask

    task automatic pulse_dp();
        dp_pulse = 1'b1; step(1); dp_pulse = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11", "status after reset", status_o, 8'h00);
        chk("R11", "enable after reset", irq_en_o, 8'h00);
        chk("R11", "irq after reset", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_vbus();
        vbus_det = 1'b1; step(1);
        chk("R1", "rise sets bit0", status_o, 8'h01);
        vbus_det = 1'b0; step(1);
        chk("R1", "fall sets bit1", status_o, 8'h03);
        wr(1'b0, 8'hFE); 
        chk("R8", "write 0 clears bit0 only", status_o, 8'h02);
        wr(1'b0, 8'h00);
        chk("R8", "write 0 clears all", status_o, 8'h00);
    endtask

    task automatic t_suspend();
        line_state = 2'b10; step(2);
        line_state = 2'b01; step(IDLE_T - 5);
        line_state = 2'b10; step(1);
        line_state = 2'b01; step(IDLE_T);
        chk("R2", "no suspend one tick early after restart", status_o, 8'h00);
        step(1);
        chk("R2", "suspend after full J run", status_o, 8'h04);
        line_state = 2'b10; step(1);
        wr(1'b0, 8'h00);
        chk("R2", "suspend cleared", status_o, 8'h00);
    endtask

    task automatic t_bact();
        pulse_sync();
        chk("R4", "sync sets bit4", status_o, 8'h10);
        line_state = 2'b01; step(J_T);
        chk("R4", "bus active held one tick before limit", status_o, 8'h10);
        step(1);
        chk("R4", "bus active cleared by J run", status_o, 8'h00);
        line_state = 2'b10; step(1);
    endtask

    task automatic t_wake();
        line_state = 2'b01; step(2);
        line_state = 2'b10; step(K_T + 3);
        chk("R5", "K without wakeup request sets nothing", status_o, 8'h00);
        line_state = 2'b01; step(2);
        rwu_req = 1'b1; line_state = 2'b10; step(K_T);
        chk("R5", "wake one tick early", status_o, 8'h00);
        step(1);
        chk("R5", "wake done after K run", status_o, 8'h20);
        rwu_req = 1'b0;
        wr(1'b0, 8'h00);
    endtask

    task automatic t_dp_irq();
        wr(1'b1, 8'h40);
        pulse_dp();
        chk("R6", "dp pulse sets bit6", status_o, 8'h40);
        chk("R9", "irq not yet high", {7'd0, irq_o}, 8'h00);
        step(1);
        chk("R9", "irq high one cycle later", {7'd0, irq_o}, 8'h01);
        wr(1'b0, 8'h00);
        chk("R9", "irq still high as flag clears", {7'd0, irq_o}, 8'h01);
        step(1);
        chk("R9", "irq low after clear", {7'd0, irq_o}, 8'h00);
        wr(1'b1, 8'h01);
        pulse_dp();
        step(1);
        chk("R9", "disabled flag gives no irq", {7'd0, irq_o}, 8'h00);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_busreset();
        wr(1'b1, 8'h48);
        pulse_dp();
        pulse_sync();
        vbus_det = 1'b1; step(1);
        chk("R7", "flags before reset", status_o, 8'h51);
        bus_rst_det = 1'b1; line_state = 2'b00; step(1);
        chk("R7", "reset leaves only bit3", status_o, 8'h08);
        chk("R8", "enables survive bus reset", irq_en_o, 8'h48);
        step(1);
        chk("R9", "irq from bus reset flag", {7'd0, irq_o}, 8'h01);
        wr(1'b0, 8'h00);
        chk("R3", "software clears during reset", status_o, 8'h00);
        step(2);
        chk("R3", "stays clear while reset held", status_o, 8'h00);
        bus_rst_det = 1'b0; step(2);
        bus_rst_det = 1'b1; step(1);
        chk("R3", "new reset sets bit3", status_o, 8'h08);
        bus_rst_det = 1'b0; step(1);
        chk("R3", "end of reset clears bit3", status_o, 8'h00);
        vbus_det = 1'b0; step(1);
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h00);
        line_state = 2'b10; step(1);
    endtask

    task automatic t_setwins();
        pulse_dp();
        sync_rx = 1'b1; reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h00;
        step(1);
        sync_rx = 1'b0; reg_we = 1'b0;
        chk("R10", "set beats same-cycle clear", status_o, 8'h10);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_regs();
        wr(1'b1, 8'hFF);
        chk("R8", "enable write with bit7 reads 7F", irq_en_o, 8'h7F);
        pulse_dp();
        wr(1'b0, 8'hFF);
        chk("R8", "writing 1 leaves flag set", status_o, 8'h40);
        wr(1'b1, 8'h00);
        chk("R8", "enable write leaves status", status_o, 8'h40);
        chk("R8", "enable cleared by write", irq_en_o, 8'h00);
        wr(1'b0, 8'h00);
    endtask

    initial begin
        rst = 1'b1; bit_tick = 1'b1; vbus_det = 1'b0; line_state = 2'b00;
        sync_rx = 1'b0; bus_rst_det = 1'b0; rwu_req = 1'b0; dp_pulse = 1'b0;
        reg_we = 1'b0; reg_sel = 1'b0; reg_wdata = 8'h00;
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_vbus();
        t_suspend();
        t_bact();
        t_wake();
        t_dp_irq();
        t_busreset();
        t_setwins();
        t_regs();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule